// File: doc/BRIEF.md
# Programmable Binary Timer Divider

This block divides an enabled clock by a selectable power of two. It can also act as a one-shot timer. A chain of binary stages advances on each rising clock edge where the count-enable input is high. A two-bit select routes one of four stage outputs to the timer output. A polarity input chooses the output level seen while the chain sits cleared.

In recycle mode the chosen stage drives the output without interruption, so the output is a square wave whose period is the chosen power of two. In single-cycle mode the output changes level once, half a period after the last clear, and then stays at that level. It stays there until a master reset, a power-on clear or a change of the mode input starts a new run.

A power-on clear acts for one cycle after the global reset releases. It can be switched off with a disable input. The master reset clears the chain at any time and wins over counting.

Top module: `binary_timer`

## Requirements
- R1: The stage chain advances by exactly one on a rising clock edge where `tick` is 1. It keeps its value on edges where `tick` is 0.
- R2: In recycle mode, the output period is 2^n enabled clock edges, with a 50% duty cycle. The select code sets n: `sel`=2'b00 gives n=TAP_00 (13 by default), 2'b01 gives n=TAP_01 (10), and 2'b11 gives n=NUM_STAGES (16).
- R3: With `sel`=2'b10 the output is still the top stage, but the lowest LOW_STAGES stages are skipped. The upper part is fed from `tick` directly, so the period is 2^(NUM_STAGES-LOW_STAGES) (256 by default).
- R4: A high `mreset` clears every stage on the next edge, whatever the count and whatever the value of `tick`.
- R5: While `rst`, `mreset` or the power-on clear is active, `timer_out` equals `pol`. It also equals `pol` at a zero count before any single-cycle flip.
- R6: In recycle mode (`mode`=1), `timer_out` is the selected stage XOR `pol`.
- R7: In single-cycle mode (`mode`=0), `timer_out` changes to the inverse of `pol` after 2^(n-1) enabled edges. It keeps that level for all later counts, until a clear.
- R8: On the first clock cycle after `rst` falls, the chain is cleared when `auto_dis`=0. It is not cleared when `auto_dis`=1.
- R9: Any change of the level of `mode` clears the chain and the single-cycle latch on the next edge.
- R10: A change of `pol` acts on `timer_out` in the same cycle and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| tick | input | 1 | Count enable |
| mreset | input | 1 | Master reset; clears the chain |
| auto_dis | input | 1 | 1 disables the power-on clear |
| sel | input | 2 | Stage select |
| mode | input | 1 | 1 = recycle, 0 = single cycle |
| pol | input | 1 | Output level while cleared |
| timer_out | output | 1 | Timer output |

## Verification
The bench builds the block with NUM_STAGES=10, LOW_STAGES=4, TAP_00=7 and TAP_01=5. The four select codes then give periods of 128, 32, 64 and 1024. A short run therefore covers a full wrap of the widest setting, the bypass path and many single-cycle flips, while the defaults would need 65536 edges for one period. A behavioural model is compared with the output on every clock. It covers gated enables, select changes in mid-count, master reset pulses, mode toggles and both settings of the power-on clear.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [1:0] {
        SEL_MID   = 2'b00,
        SEL_SHORT = 2'b01,
        SEL_SKIP  = 2'b10,
        SEL_FULL  = 2'b11
    } tap_sel_e;

    typedef struct packed {
        logic clr;
        logic hold;
    } rst_ctl_t;

    function automatic int tap_index(tap_sel_e s, int t00, int t01, int n);
        case (s)
            SEL_MID:   return t00 - 1;
            SEL_SHORT: return t01 - 1;
            default:   return n - 1;
        endcase
    endfunction

endpackage

// File: rtl/timer_rstgen.sv
module timer_rstgen
    import timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mreset,
    input  logic     auto_dis,
    input  logic     mode,
    output rst_ctl_t ctl
);
    logic por_q;
    logic mode_q;
    logic por_pulse;
    logic mode_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            por_q  <= 1'b1;
            mode_q <= mode;
        end else begin
            por_q  <= 1'b0;
            mode_q <= mode;
        end
    end

    assign por_pulse = por_q & ~auto_dis;
    assign mode_edge = mode ^ mode_q;

    always_comb begin
        ctl.clr  = mreset | por_pulse | mode_edge;
        ctl.hold = rst | mreset | por_pulse;
    end

    // R8: the power-on clear lasts a single cycle
    a_r8_por_single: assert property (@(posedge clk) disable iff (rst)
        por_pulse |=> !por_pulse);

endmodule

// File: rtl/timer_chain.sv
module timer_chain #(
    parameter int NUM_STAGES = 16,
    parameter int LOW_STAGES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  tick,
    input  logic                  bypass,
    output logic [NUM_STAGES-1:0] count
);
    localparam int HIGH_STAGES = NUM_STAGES - LOW_STAGES;

    logic [LOW_STAGES-1:0]  low_q;
    logic [HIGH_STAGES-1:0] high_q;
    logic                   low_carry;
    logic                   high_step;

    assign low_carry = &low_q;
    assign high_step = tick & (bypass | low_carry);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            low_q <= '0;
        end else if (tick) begin
            low_q <= low_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            high_q <= '0;
        end else if (high_step) begin
            high_q <= high_q + 1'b1;
        end
    end

    assign count = {high_q, low_q};

    // R4: a clear empties every stage
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

    // R2: the upper part advances when the lower part wraps
    a_r2_carry_steps: assert property (@(posedge clk) disable iff (rst)
        (tick && !bypass && !clr && (low_q == '1)) |=> (high_q == $past(high_q) + 1'b1));

    // R3: the skip path steps the upper part on every enabled edge
    a_r3_skip_steps: assert property (@(posedge clk) disable iff (rst)
        (tick && bypass && !clr) |=> (high_q == $past(high_q) + 1'b1));

    // R1: no enable, no change
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(count));

endmodule

// File: rtl/timer_outsel.sv
module timer_outsel
    import timer_pkg::*;
#(
    parameter int NUM_STAGES = 16,
    parameter int TAP_00     = 13,
    parameter int TAP_01     = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  rst_ctl_t              ctl,
    input  logic [NUM_STAGES-1:0] count,
    input  tap_sel_e              sel,
    input  logic                  mode,
    input  logic                  pol,
    output logic                  timer_out
);
    localparam int IDX_MID   = tap_index(SEL_MID,   TAP_00, TAP_01, NUM_STAGES);
    localparam int IDX_SHORT = tap_index(SEL_SHORT, TAP_00, TAP_01, NUM_STAGES);
    localparam int IDX_FULL  = tap_index(SEL_FULL,  TAP_00, TAP_01, NUM_STAGES);

    logic tap;
    logic latch_q;
    logic level;

    always_comb begin
        case (sel)
            SEL_MID:   tap = count[IDX_MID];
            SEL_SHORT: tap = count[IDX_SHORT];
            default:   tap = count[IDX_FULL];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            latch_q <= 1'b0;
        end else if (!mode && tap) begin
            latch_q <= 1'b1;
        end
    end

    assign level     = mode ? tap : (tap | latch_q);
    assign timer_out = ctl.hold ? pol : (level ^ pol);

    // R7: a set latch survives until a clear
    a_r7_latch_keeps: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !ctl.clr) |=> latch_q);

    // R7: once set in single-cycle mode the output is the inverse level
    a_r7_flipped_level: assert property (@(posedge clk) disable iff (rst)
        (!mode && latch_q && !ctl.hold) |-> (timer_out == !pol));

    // R5: empty chain and clear latch give the idle level
    a_r5_idle_level: assert property (@(posedge clk) disable iff (rst)
        ((count == '0) && !latch_q) |-> (timer_out == pol));

endmodule

// File: rtl/binary_timer.sv
module binary_timer
    import timer_pkg::*;
#(
    parameter int NUM_STAGES = 16,
    parameter int LOW_STAGES = 8,
    parameter int TAP_00     = 13,
    parameter int TAP_01     = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       mreset,
    input  logic       auto_dis,
    input  logic [1:0] sel,
    input  logic       mode,
    input  logic       pol,
    output logic       timer_out
);
    rst_ctl_t              ctl;
    logic [NUM_STAGES-1:0] count;
    tap_sel_e              sel_e;
    logic                  bypass;

    assign sel_e  = tap_sel_e'(sel);
    assign bypass = (sel_e == SEL_SKIP);

    timer_rstgen u_rstgen (
        .clk      (clk),
        .rst      (rst),
        .mreset   (mreset),
        .auto_dis (auto_dis),
        .mode     (mode),
        .ctl      (ctl)
    );

    timer_chain #(
        .NUM_STAGES (NUM_STAGES),
        .LOW_STAGES (LOW_STAGES)
    ) u_chain (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctl.clr),
        .tick   (tick),
        .bypass (bypass),
        .count  (count)
    );

    timer_outsel #(
        .NUM_STAGES (NUM_STAGES),
        .TAP_00     (TAP_00),
        .TAP_01     (TAP_01)
    ) u_outsel (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .count     (count),
        .sel       (sel_e),
        .mode      (mode),
        .pol       (pol),
        .timer_out (timer_out)
    );

    // R9: a mode level change empties the chain on the next edge
    a_r9_mode_edge_clears: assert property (@(posedge clk) disable iff (rst)
        (mode != $past(mode)) |=> (count == '0));

    // R4: master reset wins over counting
    a_r4_mreset_wins: assert property (@(posedge clk) disable iff (rst)
        (mreset && tick) |=> (count == '0));

endmodule

// File: tb/binary_timer_bench.sv
module binary_timer_bench;
    localparam int N    = 10;
    localparam int LOW  = 4;
    localparam int T00  = 7;
    localparam int T01  = 5;
    localparam int LMOD = 1 << LOW;
    localparam int HMOD = 1 << (N - LOW);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic mreset = 1'b0;
    logic auto_dis = 1'b0;
    logic [1:0] sel = 2'b00;
    logic mode = 1'b1;
    logic pol = 1'b0;
    logic timer_out;

    int total = 0;
    int fails = 0;
    bit done = 0;
    string req = "R5";

    int m_low = 0, m_high = 0, m_latch = 0, m_modeq = 1, m_porp = 1;

    always #4 clk = ~clk;

    binary_timer #(.NUM_STAGES(N), .LOW_STAGES(LOW), .TAP_00(T00), .TAP_01(T01)) u_binary_timer (
        .clk(clk), .rst(rst), .tick(tick), .mreset(mreset), .auto_dis(auto_dis),
        .sel(sel), .mode(mode), .pol(pol), .timer_out(timer_out)
    );

    function automatic int m_tap();
        int idx;
        int comb;
        comb = m_high * LMOD + m_low;
        case (sel)
            2'b00:   idx = T00 - 1;
            2'b01:   idx = T01 - 1;
            default: idx = N - 1;
        endcase
        return (comb >> idx) & 1;
    endfunction

    function automatic logic m_out();
        int lvl;
        if (rst || mreset || (m_porp != 0 && !auto_dis)) return pol;
        lvl = mode ? m_tap() : (m_tap() | m_latch);
        return logic'(lvl[0]) ^ pol;
    endfunction

    task automatic model_edge();
        int tv;
        bit clr;
        bit nb;
        if (rst) begin
            m_low = 0; m_high = 0; m_latch = 0; m_modeq = mode; m_porp = 1;
        end else begin
            tv  = m_tap();
            clr = mreset || (m_porp != 0 && !auto_dis) || (mode != m_modeq[0]);
            m_porp = 0;
            m_modeq = mode;
            if (clr) begin
                m_low = 0; m_high = 0; m_latch = 0;
            end else begin
                if (!mode && tv != 0) m_latch = 1;
                if (tick) begin
                    nb = (sel == 2'b10) || (m_low == LMOD - 1);
                    m_low = (m_low + 1) % LMOD;
                    if (nb) m_high = (m_high + 1) % HMOD;
                end
            end
        end
    endtask

    task automatic check(string r, logic act, logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: timer_out=%b expected %b at %0t", r, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check(req, timer_out, m_out());
        end
    endtask

    initial begin
        // reset state, R5 and R8
        req = "R5";
        tick = 1'b1;
        step(3);
        check("R5", timer_out, pol);
        rst = 1'b0;
        req = "R8";
        step(1);
        check("R8", timer_out, 1'b0);
        // recycle, R2 and R6
        req = "R6";
        step(300);
        sel = 2'b01; req = "R2";
        step(100);
        sel = 2'b11; pol = 1'b1; req = "R10";
        step(1100);
        // skip path, R3
        sel = 2'b10; pol = 1'b0; req = "R3";
        step(200);
        // gated enable, R1
        req = "R1";
        for (int i = 0; i < 400; i++) begin
            tick = ((i * 7) % 3) != 0;
            step(1);
        end
        tick = 1'b1;
        // master reset, R4
        sel = 2'b01; req = "R4";
        step(23);
        mreset = 1'b1;
        step(1);
        check("R4", timer_out, pol);
        step(2);
        mreset = 1'b0;
        step(1);
        check("R4", timer_out, pol);
        step(40);
        // single cycle, R7
        mode = 1'b0; req = "R9";
        step(1);
        mreset = 1'b1; step(1); mreset = 1'b0;
        req = "R7";
        step(16);
        check("R7", timer_out, 1'b1);
        step(150);
        check("R7", timer_out, 1'b1);
        // mode change restarts, R9
        mode = 1'b1; req = "R9";
        step(1);
        mode = 1'b0;
        step(2);
        check("R9", timer_out, 1'b0);
        step(200);
        // polarity during single cycle, R10
        pol = 1'b1; req = "R10";
        step(1);
        check("R10", timer_out, 1'b0);
        pol = 1'b0;
        step(5);
        sel = 2'b00; mode = 1'b1; req = "R2";
        step(300);
        // auto clear disabled, R8
        rst = 1'b1; auto_dis = 1'b1; req = "R8";
        step(2);
        rst = 1'b0;
        step(300);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule